// File: doc/BRIEF.md
# Transmit descriptor DMA channel

This block is one transmit DMA channel. It follows a chain of buffer descriptors held in memory and sends the packet bytes each descriptor points to out on a 32-bit AXI4-Stream style master port. Software first writes a current-descriptor pointer and sets the run bit. It then writes a tail-descriptor pointer. The tail write is the event that starts processing.

The channel reads every descriptor through a single word-wide memory port that uses a request/acknowledge handshake. For each descriptor it reads three words: the link to the next descriptor, the buffer address and the control word. It then reads the buffer one word at a time and presents each word as a stream beat. After the last beat it writes a completion word back into the descriptor. The register set holds run/stop, a self-clearing soft reset, interrupt enables, a halted flag and a completion interrupt bit that is cleared by writing 1 to it.

Top module: `txdma_chan`

## Requirements
- R1: After reset the status register reads 0x0000_0001 (halted) and the control, current-pointer and tail-pointer registers read 0. No stream beat, memory request or interrupt is active.
- R2: The register byte offsets are control 0x00, status 0x04, current pointer 0x08 and tail pointer 0x10. In the control register, bit 0 is run, bit 2 is soft reset and bits 14:12 are interrupt enables. Pointer writes force the low 7 bits to 0, so descriptors are aligned to 128 bytes.
- R3: A descriptor at byte address D is read at these addresses: D+0 gives the next-descriptor link, D+8 gives the buffer byte address and D+24 gives the control word. In the control word, bits 22:0 are the byte length, bit 27 is start of frame and bit 26 is end of frame. Every memory request stays asserted, with a stable address, until it is acknowledged.
- R4: Buffer words are sent in address order as ceil(length/4) beats. Every beat except the last has keep 0xF. The last beat has keep equal to the low (length mod 4) bits set, or 0xF when the length is a multiple of 4. TLAST is set only on the last beat, and only when the end-of-frame flag is set. TUSER is set only on the first beat, and only when the start-of-frame flag is set.
- R5: When a descriptor completes, the channel writes 0x8000_0000 OR length to D+28.
- R6: A tail write while the channel is running processes descriptors from the current pointer through the tail, following the links. After each completion the current pointer holds that descriptor's link. Fetching stops after the tail descriptor.
- R7: A tail write while the channel is stopped is remembered, but no memory access happens until run is set. Setting run then starts processing.
- R8: If run is cleared in the middle of a descriptor, the channel finishes that descriptor, including its write-back, and only then reports halted. Setting run clears halted at once.
- R9: Status bit 12 is set when a descriptor with the end-of-frame flag completes. Writing 1 to status bit 12 clears it. The irq output equals status bit 12 AND control bit 12.
- R10: Writing 1 to control bit 2 aborts any activity. Bit 2 reads 1 for at least one cycle and then clears itself, and every register returns to its R1 value.
- R11: While TVALID is high and TREADY is low, TVALID, TDATA, TKEEP and TLAST hold their values.
- R12: A zero-length descriptor produces no beats and still writes back 0x8000_0000.
- R13: A descriptor that links to itself, with current pointer equal to tail, is processed exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done; read data valid |
| mem_rdata | input | 32 | Memory read data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream data, little-endian byte lanes |
| m_tkeep | output | 4 | Stream byte keep |
| m_tlast | output | 1 | End of frame |
| m_tuser | output | 1 | Start of frame on the first beat |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a stop request that lands inside a descriptor. The check must show that the channel is still busy and not halted, and that it goes on to finish the descriptor. The bench gets there by holding TREADY low, which freezes the channel on its first beat. It clears run during that stall and checks the held beat and the halted flag. It then releases TREADY and checks that all beats and the write-back still arrive before halted rises. A table of single self-linked descriptors covers lengths 0, 1, 3, 5, 7, 8 and 12 with mixed frame flags. A three-descriptor ring covers link following and stopping at the tail.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   // register byte offsets
   localparam int          REG_AW   = 5;
   localparam logic [4:0]  OFS_CTL  = 5'h00;
   localparam logic [4:0]  OFS_STS  = 5'h04;
   localparam logic [4:0]  OFS_CUR  = 5'h08;
   localparam logic [4:0]  OFS_TAIL = 5'h10;

   // control and status bit positions
   localparam int CTL_RUN  = 0;
   localparam int CTL_SRST = 2;
   localparam int STS_HALT = 0;
   localparam int IRQ_LO   = 12;
   localparam int IRQ_W    = 3;

   // descriptor word indexes and control flags
   localparam int DW_NEXT = 0;
   localparam int DW_BUF  = 2;
   localparam int DW_CTL  = 6;
   localparam int DW_STS  = 7;
   localparam int CF_SOF  = 27;
   localparam int CF_EOF  = 26;

   typedef enum logic [2:0] {
      S_IDLE, S_NEXT, S_BUF, S_CTL, S_DATA, S_BEAT, S_WB
   } eng_state_t;
endpackage

// File: rtl/txdma_keep.sv
module txdma_keep #(
   parameter int LEN_W = 23,
   parameter int BYTES = 4
) (
   input  logic [LEN_W-1:0] rem,
   output logic [BYTES-1:0] keep
);
   // byte lane b is valid when more than b bytes remain
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign keep[b] = rem > LEN_W'(b);
   end
endmodule

// File: rtl/txdma_regs.sv
module txdma_regs
   import txdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_idle,
   input  logic              eng_done,
   input  logic              eng_eof,
   input  logic [ADDR_W-1:0] eng_next,
   output logic              start,
   output logic              abort,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              irq
);
   logic              run_q, srst_q, halted_q, cmp_q, pend_q;
   logic [IRQ_W-1:0]  ien_q;
   logic [ADDR_W-1:0] cur_q, tail_q, wptr;
   logic              wr_ctl, wr_sts, wr_cur, wr_tail, clr_all;
   logic              unused_wdata;

   assign wr_ctl  = reg_wr && (reg_addr == OFS_CTL);
   assign wr_sts  = reg_wr && (reg_addr == OFS_STS);
   assign wr_cur  = reg_wr && (reg_addr == OFS_CUR);
   assign wr_tail = reg_wr && (reg_addr == OFS_TAIL);
   assign wptr    = {reg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   assign clr_all = !rst_n || (srst_q && eng_idle);
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (clr_all) begin
         run_q    <= 1'b0;
         srst_q   <= 1'b0;
         ien_q    <= '0;
         halted_q <= 1'b1;
         cmp_q    <= 1'b0;
         pend_q   <= 1'b0;
         cur_q    <= '0;
         tail_q   <= '0;
      end else begin
         if (wr_ctl) begin
            run_q  <= reg_wdata[CTL_RUN];
            srst_q <= reg_wdata[CTL_SRST];
            ien_q  <= reg_wdata[IRQ_LO +: IRQ_W];
         end
         if (wr_ctl && reg_wdata[CTL_RUN])
            halted_q <= 1'b0;
         else if (!run_q && eng_idle)
            halted_q <= 1'b1;
         if (eng_done && eng_eof)
            cmp_q <= 1'b1;
         else if (wr_sts && reg_wdata[IRQ_LO])
            cmp_q <= 1'b0;
         if (eng_done)
            cur_q <= eng_next;
         else if (wr_cur)
            cur_q <= wptr;
         if (wr_tail)
            tail_q <= wptr;
         if (wr_tail)
            pend_q <= 1'b1;
         else if (eng_done && (cur_q == tail_q))
            pend_q <= 1'b0;
      end
   end

   assign start   = run_q && pend_q && eng_idle && !srst_q;
   assign abort   = srst_q;
   assign cur_ptr = cur_q;
   assign irq     = cmp_q && ien_q[0];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTL: begin
            reg_rdata[CTL_RUN]           = run_q;
            reg_rdata[CTL_SRST]          = srst_q;
            reg_rdata[IRQ_LO +: IRQ_W]   = ien_q;
         end
         OFS_STS: begin
            reg_rdata[STS_HALT] = halted_q;
            reg_rdata[IRQ_LO]   = cmp_q;
         end
         OFS_CUR:  reg_rdata = cur_q;
         OFS_TAIL: reg_rdata = tail_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R8
   halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |-> eng_idle);
   // R7
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_idle && !run_q) |=> eng_idle);
   // R10
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && eng_idle) |=> !srst_q);
   // R9
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && eng_eof) |=> cmp_q);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
   import txdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 23,
   parameter int ALIGN_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                abort,
   input  logic                start,
   input  logic [ADDR_W-1:0]   base_in,
   output logic                idle,
   output logic                done,
   output logic                eof_out,
   output logic [ADDR_W-1:0]   next_ptr,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                m_tvalid,
   input  logic                m_tready,
   output logic [DATA_W-1:0]   m_tdata,
   output logic [DATA_W/8-1:0] m_tkeep,
   output logic                m_tlast,
   output logic                m_tuser
);
   localparam int BYTES = DATA_W / 8;
   localparam int WB    = 4 * (DATA_W / 32);

   eng_state_t        st_q;
   logic [ADDR_W-1:0] base_q, next_q, ptr_q;
   logic [LEN_W-1:0]  len_q, rem_q;
   logic              sof_q, eof_q, first_q, last_beat;
   logic [DATA_W-1:0] word_q;
   logic              unused_rdata;

   assign last_beat    = rem_q <= LEN_W'(BYTES);
   assign unused_rdata = ^mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         base_q  <= '0;
         next_q  <= '0;
         ptr_q   <= '0;
         len_q   <= '0;
         rem_q   <= '0;
         sof_q   <= 1'b0;
         eof_q   <= 1'b0;
         first_q <= 1'b0;
         word_q  <= '0;
      end else if (abort) begin
         st_q <= S_IDLE;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               base_q <= base_in;
               st_q   <= S_NEXT;
            end
            S_NEXT: if (mem_ack) begin
               next_q <= {mem_rdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
               st_q   <= S_BUF;
            end
            S_BUF: if (mem_ack) begin
               ptr_q <= mem_rdata;
               st_q  <= S_CTL;
            end
            S_CTL: if (mem_ack) begin
               len_q   <= mem_rdata[LEN_W-1:0];
               rem_q   <= mem_rdata[LEN_W-1:0];
               sof_q   <= mem_rdata[CF_SOF];
               eof_q   <= mem_rdata[CF_EOF];
               first_q <= 1'b1;
               st_q    <= (mem_rdata[LEN_W-1:0] == '0) ? S_WB : S_DATA;
            end
            S_DATA: if (mem_ack) begin
               word_q <= mem_rdata;
               st_q   <= S_BEAT;
            end
            S_BEAT: if (m_tready) begin
               first_q <= 1'b0;
               ptr_q   <= ptr_q + ADDR_W'(BYTES);
               rem_q   <= last_beat ? '0 : rem_q - LEN_W'(BYTES);
               st_q    <= last_beat ? S_WB : S_DATA;
            end
            S_WB: if (mem_ack) st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b1;
      mem_addr = '0;
      case (st_q)
         S_NEXT:  mem_addr = base_q + ADDR_W'(WB * DW_NEXT);
         S_BUF:   mem_addr = base_q + ADDR_W'(WB * DW_BUF);
         S_CTL:   mem_addr = base_q + ADDR_W'(WB * DW_CTL);
         S_DATA:  mem_addr = ptr_q;
         S_WB:    mem_addr = base_q + ADDR_W'(WB * DW_STS);
         default: mem_req  = 1'b0;
      endcase
   end

   assign mem_we    = (st_q == S_WB);
   assign mem_wdata = {1'b1, {(DATA_W-1-LEN_W){1'b0}}, len_q};
   assign idle      = (st_q == S_IDLE);
   assign done      = (st_q == S_WB) && mem_ack;
   assign eof_out   = eof_q;
   assign next_ptr  = next_q;
   assign m_tvalid  = (st_q == S_BEAT);
   assign m_tdata   = word_q;
   assign m_tlast   = m_tvalid && last_beat && eof_q;
   assign m_tuser   = m_tvalid && first_q && sof_q;

   txdma_keep #(.LEN_W(LEN_W), .BYTES(BYTES)) u_keep (
      .rem  (rem_q),
      .keep (m_tkeep)
   );

   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R11
   stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                   && $stable(m_tlast)));
   // R4
   keep_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> m_tkeep[0]);
endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
   import txdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 23,
   parameter int ALIGN_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                m_tvalid,
   input  logic                m_tready,
   output logic [DATA_W-1:0]   m_tdata,
   output logic [DATA_W/8-1:0] m_tkeep,
   output logic                m_tlast,
   output logic                m_tuser
   ,output logic               irq
);
   if (DATA_W != 32 || ADDR_W != DATA_W) begin : g_bad_width
      $error("txdma_chan: word and address width must both be 32");
   end
   if (LEN_W < 1 || LEN_W > CF_EOF) begin : g_bad_len
      $error("txdma_chan: length field overlaps frame flags");
   end
   if (ALIGN_BITS < 3 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("txdma_chan: descriptor alignment out of range");
   end

   logic              eng_idle, eng_done, eng_eof, start, abort;
   logic [ADDR_W-1:0] eng_next, cur_ptr;

   txdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .eng_idle, .eng_done, .eng_eof, .eng_next,
      .start, .abort, .cur_ptr, .irq
   );

   txdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                  .ALIGN_BITS(ALIGN_BITS)) u_eng (
      .clk, .rst_n, .abort, .start,
      .base_in  (cur_ptr),
      .idle     (eng_idle),
      .done     (eng_done),
      .eof_out  (eng_eof),
      .next_ptr (eng_next),
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
      .m_tvalid, .m_tready, .m_tdata, .m_tkeep, .m_tlast, .m_tuser
   );
endmodule

// File: tb/txdma_chan_tb.sv
module txdma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        m_tvalid, m_tready = 1'b1, m_tlast, m_tuser, irq;
   logic [31:0] m_tdata;
   logic [3:0]  m_tkeep;

   int total = 0, bad = 0;
   int wb_cnt = 0, acc_cnt = 0, cap_n = 0;
   logic [31:0] mem    [0:4095];
   logic [31:0] wb_mem [0:4095];
   logic [31:0] cap_data [0:255];
   logic [3:0]  cap_keep [0:255];
   logic        cap_last [0:255];
   logic        cap_sof  [0:255];

   always #5 clk = ~clk;

   txdma_chan u_dut (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
      .m_tvalid, .m_tready, .m_tdata, .m_tkeep, .m_tlast, .m_tuser, .irq
   );

   // memory responder: acknowledges one cycle after a request is seen
   always @(negedge clk) begin
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         mem_ack <= 1'b1;
         acc_cnt <= acc_cnt + 1;
         if (mem_we) begin
            wb_mem[mem_addr[13:2]] <= mem_wdata;
            wb_cnt <= wb_cnt + 1;
         end else mem_rdata <= mem[mem_addr[13:2]];
      end
   end

   // stream sink: records beats that will be accepted at the next edge
   always @(negedge clk) begin
      #1;
      if (rst_n && m_tvalid && m_tready) begin
         cap_data[cap_n] = m_tdata;
         cap_keep[cap_n] = m_tkeep;
         cap_last[cap_n] = m_tlast;
         cap_sof[cap_n]  = m_tuser;
         cap_n = cap_n + 1;
      end
   end

   function automatic logic [31:0] pat(input int a);
      return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_wb(input int target);
      for (int i = 0; i < 3000 && wb_cnt < target; i++) @(negedge clk);
      tick(2);
   endtask

   task automatic put_desc(input int d, input int nxt, input int bufa, input int len,
                           input bit sof, input bit eof);
      mem[(d >> 2) + 0] = 32'(nxt);
      mem[(d >> 2) + 2] = 32'(bufa);
      mem[(d >> 2) + 6] = 32'(len) | (32'(sof) << 27) | (32'(eof) << 26);
   endtask

   // compares beats captured from index n0 against the buffer at bufa
   task automatic check_frame(input string req, input int n0, input int bufa,
                              input int len, input bit sof, input bit eof);
      int nb, miss, rem;
      nb = (len + 3) / 4;
      chk(cap_n - n0 == nb, {req, " beat count"}, 32'(cap_n - n0), 32'(nb));
      if (cap_n - n0 == nb && nb > 0) begin
         miss = 0;
         for (int k = 0; k < nb; k++) begin
            if (cap_data[n0 + k] !== pat((bufa >> 2) + k)) miss++;
            if (k < nb - 1 && (cap_keep[n0 + k] !== 4'hF || cap_last[n0 + k])) miss++;
            if (k > 0 && cap_sof[n0 + k]) miss++;
         end
         chk(miss == 0, {req, " data/keep mismatches"}, 32'(miss), 0);
         rem = len - 4 * (nb - 1);
         chk(cap_keep[n0 + nb - 1] == 4'((1 << rem) - 1), {req, " final keep"},
             32'(cap_keep[n0 + nb - 1]), 32'((1 << rem) - 1));
         chk(cap_last[n0 + nb - 1] == eof && cap_sof[n0] == sof, {req, " last/sof flags"},
             {30'd0, cap_last[n0 + nb - 1], cap_sof[n0]}, {30'd0, eof, sof});
      end
   endtask

   // {length[22:0], sof, eof}
   localparam logic [24:0] VEC [0:6] = '{
      {23'd8,  1'b1, 1'b1},
      {23'd5,  1'b1, 1'b1},
      {23'd3,  1'b1, 1'b0},
      {23'd1,  1'b0, 1'b1},
      {23'd12, 1'b0, 1'b0},
      {23'd0,  1'b1, 1'b1},
      {23'd7,  1'b1, 1'b1}
   };

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v, d0;
      int n0, w0, a0;
      for (int i = 0; i < 4096; i++) mem[i] = pat(i);
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      rd(5'h04, v); chk(v == 32'h1, "R1 status after reset", v, 32'h1);
      rd(5'h00, v); chk(v == 0, "R1 control after reset", v, 0);
      rd(5'h08, v); chk(v == 0, "R1 current pointer after reset", v, 0);
      rd(5'h10, v); chk(v == 0, "R1 tail pointer after reset", v, 0);
      chk(!m_tvalid && !mem_req && !irq, "R1 outputs idle",
          {29'd0, m_tvalid, mem_req, irq}, 0);

      // R2 pointer alignment and control readback
      wr(5'h08, 32'h0000_02FF);
      rd(5'h08, v); chk(v == 32'h280, "R2 pointer low bits cleared", v, 32'h280);
      wr(5'h00, 32'h0000_1001);
      rd(5'h00, v); chk(v == 32'h1001, "R2 control readback", v, 32'h1001);
      rd(5'h04, v); chk(v[0] == 1'b0, "R8 run clears halted", v, 32'h0);

      // R3 R4 R5 R9 R12 R13: table of single self-linked descriptors
      for (int i = 0; i < 7; i++) begin
         int d, b, len;
         bit sof, eof;
         d = 32'h200 + i * 32'h80;
         b = 32'h1000 + i * 32'h40;
         len = int'(VEC[i][24:2]); sof = VEC[i][1]; eof = VEC[i][0];
         put_desc(d, d, b, len, sof, eof);
         n0 = cap_n; w0 = wb_cnt;
         wr(5'h08, 32'(d));
         wr(5'h10, 32'(d));
         wait_wb(w0 + 1);
         check_frame($sformatf("R4 vec%0d", i), n0, b, len, sof, eof);
         chk(wb_mem[(d >> 2) + 7] == (32'h8000_0000 | 32'(len)), "R5 R12 write-back word",
             wb_mem[(d >> 2) + 7], 32'h8000_0000 | 32'(len));
         rd(5'h04, v);
         chk(v[12] == eof && irq == eof, "R9 completion bit and irq",
             {v[12], 30'd0, irq}, {eof, 30'd0, eof});
         wr(5'h04, 32'h0000_1000);
         rd(5'h04, v);
         chk(v[12] == 1'b0 && !irq, "R9 write-1 clear", {v[12], 30'd0, irq}, 0);
         tick(20);
         chk(wb_cnt == w0 + 1, "R13 self link processed once", 32'(wb_cnt), 32'(w0 + 1));
      end

      // R6 three-descriptor ring, stops at tail
      put_desc(32'h800, 32'h880, 32'h2000, 4, 1, 0);
      put_desc(32'h880, 32'h900, 32'h2100, 6, 0, 0);
      put_desc(32'h900, 32'h800, 32'h2200, 2, 0, 1);
      n0 = cap_n; w0 = wb_cnt;
      wr(5'h08, 32'h800);
      wr(5'h10, 32'h900);
      wait_wb(w0 + 3);
      tick(30);
      chk(wb_cnt == w0 + 3, "R6 three write-backs then stop", 32'(wb_cnt), 32'(w0 + 3));
      chk(cap_n - n0 == 4, "R6 ring beat count", 32'(cap_n - n0), 4);
      chk(cap_data[n0 + 1] == pat(32'h2100 >> 2) && cap_data[n0 + 3] == pat(32'h2200 >> 2),
          "R6 link order", cap_data[n0 + 3], pat(32'h2200 >> 2));
      chk(wb_mem[(32'h880 >> 2) + 7] == 32'h8000_0006, "R6 middle write-back",
          wb_mem[(32'h880 >> 2) + 7], 32'h8000_0006);
      rd(5'h08, v); chk(v == 32'h800, "R6 current pointer follows tail link", v, 32'h800);

      // R7 tail written while stopped
      wr(5'h00, 32'h0000_1000);
      tick(3);
      put_desc(32'hA00, 32'hA00, 32'h2400, 8, 1, 1);
      wr(5'h08, 32'hA00);
      wr(5'h10, 32'hA00);
      a0 = acc_cnt; n0 = cap_n; w0 = wb_cnt;
      tick(30);
      chk(acc_cnt == a0, "R7 no fetch while stopped", 32'(acc_cnt), 32'(a0));
      rd(5'h04, v); chk(v[0] == 1'b1, "R7 still halted", v, 32'h1);
      wr(5'h00, 32'h0000_1001);
      wait_wb(w0 + 1);
      check_frame("R7 after run", n0, 32'h2400, 8, 1, 1);
      wr(5'h04, 32'h0000_1000);

      // R8 R11 stop during a stalled beat
      m_tready = 1'b0;
      put_desc(32'hB00, 32'hB00, 32'h2800, 16, 1, 1);
      n0 = cap_n; w0 = wb_cnt;
      wr(5'h08, 32'hB00);
      wr(5'h10, 32'hB00);
      for (int i = 0; i < 200 && !m_tvalid; i++) @(negedge clk);
      d0 = m_tdata;
      tick(3);
      chk(m_tvalid && m_tdata == d0, "R11 beat held under back-pressure", m_tdata, d0);
      wr(5'h00, 32'h0000_1000);
      tick(2);
      rd(5'h04, v); chk(v[0] == 1'b0, "R8 not halted mid-descriptor", v, 0);
      m_tready = 1'b1;
      wait_wb(w0 + 1);
      tick(3);
      rd(5'h04, v); chk(v[0] == 1'b1, "R8 halted after finishing", v, 32'h1);
      check_frame("R8 stopped descriptor completes", n0, 32'h2800, 16, 1, 1);
      wr(5'h00, 32'h0000_1001);
      rd(5'h04, v); chk(v[0] == 1'b0, "R8 run clears halted again", v, 0);

      // R10 soft reset
      wr(5'h00, 32'h0000_1005);
      rd(5'h00, v); chk(v[2] == 1'b1, "R10 reset bit reads one", v, 32'h4);
      tick(3);
      rd(5'h00, v); chk(v == 0, "R10 control cleared", v, 0);
      rd(5'h04, v); chk(v == 32'h1, "R10 status halted", v, 32'h1);
      rd(5'h08, v); chk(v == 0, "R10 current pointer cleared", v, 0);
      rd(5'h10, v); chk(v == 0, "R10 tail pointer cleared", v, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule